// File: doc/BRIEF.md
# Dual-Divider Three-State Phase Comparator

This block sits at the digital front of a synthesizer loop. A reference divider counts reference ticks, and a feedback divider counts ticks derived from the oscillator. Each divider emits a one-cycle terminal-count pulse once per period. A three-state detector compares the two pulse streams. When the reference pulse arrives first, it drives a pump-up request until the feedback pulse arrives. When the feedback pulse arrives first, it drives a pump-down request until the reference pulse arrives. The request lasts exactly as many cycles as the two pulses are apart. When the detector is idle, the pump is released (drive enable low).

Three control inputs act on the detector's output. An invert control swaps the up and down roles, which suits a loop whose filter or oscillator has opposite sense. A disable control releases the pump. A clamp control drives the output steadily to the discharge level and empties the detector, which holds the loop off lock. The analog pump, the filter and the oscillator lie outside the block. Both ticks are clock enables in the block's clock domain.

Top module: `phase_cmp_div`

## Requirements
- R1: The reference divider pulses `ref_tc` for one cycle in the cycle after every M-th sampled `ref_tick`. M is the loaded modulus, from 1 to 1023. A field value of 0 loads as 1. After reset M is 20.
- R2: The feedback divider pulses `fb_tc` for one cycle in the cycle after every M-th sampled `fb_tick`. M is the loaded modulus, from 2 to 16383. Field values 0 and 1 load as 2. After reset M is 120.
- R3: A changed `ref_div` or `fb_div` value is loaded only on that divider's terminal count, so the period in progress finishes at the old modulus.
- R4: Suppose `cp_invert`, `cp_off` and `cp_clamp` are low. If a `ref_tc` pulse leads the next `fb_tc` pulse by k cycles, `pump_up` and `pump_oe` are high for exactly k cycles. If `fb_tc` leads by k cycles, `pump_dn` and `pump_oe` are high for exactly k cycles. `pump_up` and `pump_dn` are never high together.
- R5: Coincident `ref_tc` and `fb_tc` pulses produce no pump activity. While no edge is pending, `pump_up`, `pump_dn` and `pump_oe` are all low.
- R6: With `cp_invert` high, the up and down roles of R4 are exchanged: a leading reference drives `pump_dn` and a leading feedback drives `pump_up`.
- R7: With `cp_off` high and `cp_clamp` low, `pump_up`, `pump_dn` and `pump_oe` are low whatever the edge timing.
- R8: With `cp_clamp` high, `pump_dn` and `pump_oe` are high and `pump_up` is low, even when `cp_off` is high. While the clamp is high the detector state is cleared, so an edge pending at that time produces no pump activity after release.
- R9: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference clock enable, one count per sampled high cycle |
| fb_tick | input | 1 | Feedback clock enable, one count per sampled high cycle |
| ref_div | input | RW (10) | Reference divider modulus |
| fb_div | input | NW (14) | Feedback divider modulus |
| cp_invert | input | 1 | Swap pump up/down roles |
| cp_off | input | 1 | Release the pump |
| cp_clamp | input | 1 | Force discharge and clear the detector |
| ref_tc | output | 1 | Reference divider terminal-count pulse |
| fb_tc | output | 1 | Feedback divider terminal-count pulse |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_oe | output | 1 | Pump drive enable, low means high impedance |

## Verification
The dividers run under continuous ticks with the modulus changed mid-period. This separates loading at the terminal count from immediate loading, and it also applies the out-of-range field values. The detector is driven with reference-leading, feedback-leading and coincident edge pairs at several spacings. The pulse width and the active output then show whether the edge order, the width in cycles and the idle state are right. The same edge pairs are repeated under inversion, disable, clamp and clamp with disable, which shows the role swap, the override priority and the discarding of a pending edge.

// File: rtl/phase_cmp_div.sv
module phase_cmp_div #(
  parameter int RW     = 10,
  parameter int NW     = 14,
  parameter int R_INIT = 20,
  parameter int N_INIT = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          fb_tick,
  input  logic [RW-1:0] ref_div,
  input  logic [NW-1:0] fb_div,
  input  logic          cp_invert,
  input  logic          cp_off,
  input  logic          cp_clamp,
  output logic          ref_tc,
  output logic          fb_tc,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          pump_oe
);

  logic [RW-1:0] r_cnt, r_mod;
  logic [NW-1:0] n_cnt, n_mod;
  logic          lead_r, lead_n;

  wire [RW-1:0] r_next = (ref_div == '0) ? RW'(1) : ref_div;
  wire [NW-1:0] n_next = (fb_div < NW'(2)) ? NW'(2) : fb_div;
  wire          r_last = (r_cnt == r_mod - RW'(1));
  wire          n_last = (n_cnt == n_mod - NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt  <= '0;
      r_mod  <= RW'(R_INIT);
      ref_tc <= 1'b0;
    end else begin
      ref_tc <= ref_tick & r_last;
      if (ref_tick) begin
        if (r_last) begin
          r_cnt <= '0;
          r_mod <= r_next;
        end else begin
          r_cnt <= r_cnt + RW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt <= '0;
      n_mod <= NW'(N_INIT);
      fb_tc <= 1'b0;
    end else begin
      fb_tc <= fb_tick & n_last;
      if (fb_tick) begin
        if (n_last) begin
          n_cnt <= '0;
          n_mod <= n_next;
        end else begin
          n_cnt <= n_cnt + NW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_r <= 1'b0;
      lead_n <= 1'b0;
    end else if (cp_clamp) begin
      lead_r <= 1'b0;
      lead_n <= 1'b0;
    end else begin
      lead_r <= ref_tc | (lead_r & ~lead_n);
      lead_n <= fb_tc  | (lead_n & ~lead_r);
    end
  end

  wire up_raw = lead_r & ~lead_n;
  wire dn_raw = lead_n & ~lead_r;
  wire live   = ~cp_clamp & ~cp_off;

  assign pump_up = live & (cp_invert ? dn_raw : up_raw);
  assign pump_dn = cp_clamp | (live & (cp_invert ? up_raw : dn_raw));
  assign pump_oe = cp_clamp | (live & (up_raw | dn_raw));

endmodule

// File: rtl/phase_cmp_div_chk.sv
module phase_cmp_div_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic fb_tick,
  input logic cp_invert,
  input logic cp_off,
  input logic cp_clamp,
  input logic ref_tc,
  input logic fb_tc,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_oe
);

  AST_REF_TC_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tc |-> $past(ref_tick)); // R1

  AST_FB_TC_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tc |-> $past(fb_tick)); // R2

  AST_UP_RISE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pump_up) && !cp_invert && !$past(cp_invert) && !cp_off && !$past(cp_off)
     && !cp_clamp && !$past(cp_clamp)) |-> $past(ref_tc)); // R4

  AST_UP_DN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn)); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_oe |-> (!pump_up && !pump_dn)); // R5

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_off && !cp_clamp) |-> !pump_oe); // R7

  AST_CLAMP_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    cp_clamp |-> (pump_dn && pump_oe && !pump_up)); // R8

  AST_CLAMP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cp_clamp) && !cp_off) |-> !pump_up && !(pump_dn && !$past(fb_tc) && !cp_invert)); // R8

endmodule

bind phase_cmp_div phase_cmp_div_chk chk (.*);

// File: tb/phase_cmp_div_test.sv
`timescale 1ns/1ps
module phase_cmp_div_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b0, fb_tick = 1'b0;
  logic [9:0]  ref_div = 10'd1;
  logic [13:0] fb_div = 14'd2;
  logic cp_invert = 1'b0, cp_off = 1'b0, cp_clamp = 1'b0;
  logic ref_tc, fb_tc, pump_up, pump_dn, pump_oe;

  int checks = 0, fails = 0;
  int up_cnt = 0, dn_cnt = 0, oe_cnt = 0;

  always #2.5 clk = ~clk;

  phase_cmp_div uut (.*);

  always @(negedge clk) begin
    up_cnt <= up_cnt + int'(pump_up);
    dn_cnt <= dn_cnt + int'(pump_dn);
    oe_cnt <= oe_cnt + int'(pump_oe);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    @(posedge clk); #1;
    up_cnt = 0; dn_cnt = 0; oe_cnt = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 pump_up", pump_up, 0);
    chk("R9 pump_dn", pump_dn, 0);
    chk("R9 pump_oe", pump_oe, 0);
    chk("R9 ref_tc", ref_tc, 0);
    chk("R9 fb_tc", fb_tc, 0);
  endtask

  task automatic t_ref_div();
    int tcs[6];
    int n = 0;
    @(posedge clk); #1;
    ref_div = 10'd5; ref_tick = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (ref_tc && n < 6) begin
        tcs[n] = i; n++;
        if (n == 3) ref_div = 10'd0;
      end
    end
    ref_tick = 1'b0;
    chk("R1 first period at reset modulus 20", tcs[0], 20);
    chk("R3 old period kept, next at +5", tcs[1], 25);
    chk("R1 period 5", tcs[2], 30);
    chk("R3 zero field waits for terminal count", tcs[3], 35);
    chk("R1 zero field divides by 1", tcs[4], 36);
    ref_div = 10'd1;
  endtask

  task automatic t_fb_div();
    int tcs[6];
    int n = 0;
    @(posedge clk); #1;
    fb_div = 14'd3; fb_tick = 1'b1;
    for (int i = 1; i <= 135; i++) begin
      @(posedge clk); @(negedge clk);
      if (fb_tc && n < 6) begin
        tcs[n] = i; n++;
        if (n == 3) fb_div = 14'd1;
      end
    end
    fb_tick = 1'b0;
    chk("R2 first period at reset modulus 120", tcs[0], 120);
    chk("R3 feedback new modulus 3", tcs[1], 123);
    chk("R3 feedback one field waits", tcs[3], 129);
    chk("R2 feedback one field divides by 2", tcs[4], 131);
    fb_div = 14'd2;
  endtask

  task automatic prime();
    bit seen = 0;
    @(posedge clk); #1; cp_clamp = 1'b1;
    for (int k = 0; k < 4 && !seen; k++) begin
      @(posedge clk); #1; fb_tick = 1'b1;
      @(posedge clk); #1; fb_tick = 1'b0;
      @(negedge clk); if (fb_tc) seen = 1;
    end
    @(posedge clk); #1; cp_clamp = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic phase(input string req, input int ra, input int fa,
                       input int eu, input int ed, input int eo);
    int last;
    prime();
    clr_counts();
    last = (ra > fa ? ra : fa) + 6;
    for (int t = 0; t <= last; t++) begin
      ref_tick = (t == ra);
      fb_tick  = (t == fa - 1) || (t == fa);
      @(posedge clk); #1;
    end
    ref_tick = 1'b0; fb_tick = 1'b0;
    @(negedge clk);
    chk({req, " up width"}, up_cnt, eu);
    chk({req, " down width"}, dn_cnt, ed);
    chk({req, " drive width"}, oe_cnt, eo);
  endtask

  task automatic t_clamp();
    prime();
    clr_counts();
    cp_clamp = 1'b1; cp_off = 1'b1; ref_tick = 1'b1;
    repeat (5) begin @(posedge clk); #1; end
    ref_tick = 1'b0; cp_clamp = 1'b0; cp_off = 1'b0;
    chk("R8 clamp drives down over disable", dn_cnt, 5);
    chk("R8 clamp drive enable", oe_cnt, 5);
    chk("R8 clamp no up", up_cnt, 0);
    prime();
    ref_tick = 1'b1; @(posedge clk); #1; ref_tick = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    cp_clamp = 1'b1; repeat (2) begin @(posedge clk); #1; end
    cp_clamp = 1'b0;
    clr_counts();
    repeat (6) begin @(posedge clk); #1; end
    chk("R8 pending edge discarded, up", up_cnt, 0);
    chk("R8 pending edge discarded, drive", oe_cnt, 0);
  endtask

  initial begin
    #50000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ref_div();
    t_fb_div();
    phase("R4 ref leads 3", 1, 4, 3, 0, 3);
    phase("R4 ref leads 7", 2, 9, 7, 0, 7);
    phase("R4 fb leads 4", 6, 2, 0, 4, 4);
    phase("R5 coincident", 3, 3, 0, 0, 0);
    cp_invert = 1'b1;
    phase("R6 inverted ref leads 4", 1, 5, 0, 4, 4);
    phase("R6 inverted fb leads 2", 4, 2, 2, 0, 2);
    cp_invert = 1'b0;
    cp_off = 1'b1;
    phase("R7 disabled ref leads 5", 1, 6, 0, 0, 0);
    cp_off = 1'b0;
    phase("R7 re-enabled idle then ref leads 2", 1, 3, 2, 0, 2);
    t_clamp();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule